// File: doc/BRIEF.md
# SM4 Round-Key Expander

This block turns a 128-bit SM4 cipher key into the 32 round keys of 32 bits that the cipher rounds consume. A one-cycle start pulse captures the key; from the next clock edge on, the block derives one round key per cycle and writes it into an internal 32-entry register store. When the last key is written, a done flag rises and stays high until the next start.

An encryption datapath reads the store from index 0 upward, and a decryption datapath reads it from index 31 downward, through one shared read index that is decoded combinationally. The byte substitution used by the schedule sits inside the block as a 256-entry table. Its contents are computed at elaboration from the field arithmetic that defines it, so no literal table appears in the source. Cipher rounds, chaining modes and data handling are outside this block.

Top module: `sm4_key_expander`

## Requirements
- R1: While and after reset, `done_o` is low.
- R2: The key is split into four 32-bit words with word 0 taken from `key_i[127:96]` and word 3 from `key_i[31:0]`. Words 0 to 3 are XORed with 0xa3b1bac6, 0x56aa3350, 0x677d9197 and 0xb27022dc respectively, giving K[0..3]. For key 0x0123456789abcdeffedcba9876543210, round key 0 is 0xf12186f9.
- R3: For i = 0..31, K[i+4] = K[i] ^ T'(K[i+1] ^ K[i+2] ^ K[i+3] ^ CK[i]). Store entry i holds K[i+4]. For the key in R2, entry 31 is 0x9124a012.
- R4: `done_o` rises exactly 32 rising clock edges after the edge that samples `start_i` high, and is low at edge 31.
- R5: Once `done_o` is high with no new start, `done_o` stays high and every store entry keeps its value.
- R6: A start pulse at any time, mid-expansion or after completion, drops `done_o` at the sampling edge. It discards all progress and expands the newly presented key from round 0, with done following R4 from that pulse.
- R7: `rd_key_o` equals store entry `rd_idx_i` in the same cycle, for any index in any order, including descending order for decryption.
- R8: T' substitutes each of the four bytes through S and then returns y ^ rotl(y,13) ^ rotl(y,23). S(x) = M(inv(M(x) ^ 0xd3)) ^ 0xd3 over GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, with inv(0) = 0. Bit i of M(v) is the parity of (0xa7 rotated left by i) AND v. This gives S(0x00) = 0xd6.
- R9: Byte j of CK[i] is (4i+j)*7 mod 256, where byte 0 is bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that captures `key_i` and starts expansion |
| key_i | input | 128 | Cipher key, most significant word first |
| rd_idx_i | input | 5 | Round-key store read index |
| done_o | output | 1 | All 32 round keys are valid in the store |
| rd_key_o | output | 32 | Round key at `rd_idx_i` |

## Verification
The reference key with its known first and last round keys anchors the byte ordering, the whitening constants and the substitution table against fixed values. An all-zero key isolates the contribution of the constants and the S-box. An all-ones key and an arbitrary key exercise every byte lane with dense bit patterns. A start issued ten cycles into a run, followed by a start issued after completion, distinguishes a true restart from a resumed or merged schedule. Reading every entry in descending order after a long idle gap confirms that the store holds its contents and that random-order access works.

// File: rtl/sm4ks_pkg.sv
package sm4ks_pkg;

    localparam int RK_COUNT = 32;
    localparam int WORD_W   = 32;
    localparam int KEY_W    = 4 * WORD_W;
    localparam int IDX_W    = $clog2(RK_COUNT);
    localparam logic [7:0] FIELD_LOW = 8'hF5;  // x^8 reduction term
    localparam logic [7:0] AFF_ROW   = 8'hA7;
    localparam logic [7:0] AFF_CONST = 8'hD3;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        word_t [3:0]      win;   // win[0] is the oldest word K[i]
    } ks_state_t;

    function automatic logic [7:0] rotl8(logic [7:0] v, int n);
        logic [15:0] t;
        t = {v, v} << n;
        return t[15:8];
    endfunction

    function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? ({aa[6:0], 1'b0} ^ FIELD_LOW) : {aa[6:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [7:0] gf_inv(logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = a;
        e = 8'hFE;               // a^254
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] affine(logic [7:0] v);
        logic [7:0] y;
        for (int i = 0; i < 8; i++) y[i] = ^(rotl8(AFF_ROW, i) & v);
        return y;
    endfunction

    function automatic logic [7:0] sbox_calc(logic [7:0] x);
        return affine(gf_inv(affine(x) ^ AFF_CONST)) ^ AFF_CONST;
    endfunction

    function automatic word_t ck_word(int i);
        word_t w;
        for (int j = 0; j < 4; j++) w[31-8*j -: 8] = 8'((4 * i + j) * 7);
        return w;
    endfunction

    function automatic word_t fk_word(int j);
        case (j)
            0:       return 32'ha3b1bac6;
            1:       return 32'h56aa3350;
            2:       return 32'h677d9197;
            default: return 32'hb27022dc;
        endcase
    endfunction

endpackage

// File: rtl/sm4ks_sbox.sv
module sm4ks_sbox
    import sm4ks_pkg::*;
(
    input  logic [7:0] a_i,
    output logic [7:0] y_o
);
    localparam int ENTRIES = 256;

    logic [7:0] rom [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
        localparam logic [7:0] VAL = sbox_calc(8'(g));
        assign rom[g] = VAL;
    end

    assign y_o = rom[a_i];
endmodule

// File: rtl/sm4ks_tkey.sv
module sm4ks_tkey
    import sm4ks_pkg::*;
(
    input  word_t x_i,
    output word_t y_o
);
    localparam int LANES = WORD_W / 8;

    word_t sub;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        sm4ks_sbox u_sbox (
            .a_i(x_i[8*b +: 8]),
            .y_o(sub[8*b +: 8])
        );
    end

    assign y_o = sub ^ {sub[18:0], sub[31:19]} ^ {sub[8:0], sub[31:9]};
endmodule

// File: rtl/sm4ks_store.sv
module sm4ks_store #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sm4_key_expander.sv
module sm4_key_expander
    import sm4ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             done_o,
    output logic [WORD_W-1:0] rd_key_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RK_COUNT - 1);

    ks_state_t st_d, st_q;
    word_t     mix_w;
    word_t     tk_w;
    word_t     next_w;

    assign mix_w  = st_q.win[1] ^ st_q.win[2] ^ st_q.win[3] ^ ck_word(int'(st_q.idx));
    assign next_w = st_q.win[0] ^ tk_w;

    sm4ks_tkey u_tkey (
        .x_i(mix_w),
        .y_o(tk_w)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            for (int j = 0; j < 4; j++) begin
                st_d.win[j] = key_i[KEY_W-1-WORD_W*j -: WORD_W] ^ fk_word(j);
            end
            st_d.idx  = '0;
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
        end else if (st_q.busy) begin
            st_d.win[0] = st_q.win[1];
            st_d.win[1] = st_q.win[2];
            st_d.win[2] = st_q.win[3];
            st_d.win[3] = next_w;
            st_d.idx    = st_q.idx + 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sm4ks_store #(
        .DEPTH(RK_COUNT),
        .W    (WORD_W)
    ) u_store (
        .clk    (clk),
        .we_i   (st_q.busy),
        .waddr_i(st_q.idx),
        .wdata_i(next_w),
        .raddr_i(rd_idx_i),
        .rdata_o(rd_key_o)
    );

    assign done_o = st_q.done;
endmodule

// File: rtl/sm4ks_chk.sv
module sm4ks_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic done_o
);
    localparam int RUN_LEN = 32;
    localparam int CNT_W   = $clog2(RUN_LEN) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] since_start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      since_start_q <= CNT_MAX;
        else if (start_i)                since_start_q <= '0;
        else if (since_start_q != CNT_MAX) since_start_q <= since_start_q + 1'b1;
    end

    // R4
    count_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> since_start_q == CNT_W'(RUN_LEN));

    // R6
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R6
    done_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(start_i));
endmodule

bind sm4_key_expander sm4ks_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .done_o (done_o)
);

// File: tb/sim_sm4_key_expander.sv
module sim_sm4_key_expander;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [4:0]   rd_idx = '0;
    logic         done;
    logic [31:0]  rd_key;

    int n_tests = 0;
    int n_fail  = 0;
    int pushed  = 0;
    int scored  = 0;

    typedef struct {
        int          idx;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    logic [7:0]  m_sbox [256];
    logic [31:0] m_rk   [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    sm4_key_expander u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .key_i   (key),
        .rd_idx_i(rd_idx),
        .done_o  (done),
        .rd_key_o(rd_key)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [8:0] aa;
        logic [7:0] acc;
        acc = '0;
        aa  = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa[7:0];
            aa = aa << 1;
            if (aa[8]) aa = aa ^ 9'h1F5;
        end
        return acc;
    endfunction

    function automatic logic [7:0] m_inv(logic [7:0] a);
        for (int c = 1; c < 256; c++) begin
            if (m_mul(a, 8'(c)) == 8'h01) return 8'(c);
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] m_aff(logic [7:0] v);
        logic [7:0] rows [8];
        logic [7:0] rv;
        logic [7:0] y;
        rows = '{8'hE5, 8'hF2, 8'h79, 8'hBC, 8'h5E, 8'h2F, 8'h97, 8'hCB};
        for (int i = 0; i < 8; i++) rv[i] = v[7-i];
        for (int i = 0; i < 8; i++) y[i] = ^(rows[i] & rv);
        return y;
    endfunction

    function automatic logic [31:0] m_tkey(logic [31:0] x);
        logic [31:0] s;
        for (int b = 0; b < 4; b++) s[8*b +: 8] = m_sbox[x[8*b +: 8]];
        return s ^ {s[18:0], s[31:19]} ^ {s[8:0], s[31:9]};
    endfunction

    task automatic m_expand(input logic [127:0] k);
        logic [31:0] w [36];
        logic [31:0] fk [4];
        logic [31:0] ck;
        fk = '{32'ha3b1bac6, 32'h56aa3350, 32'h677d9197, 32'hb27022dc};
        for (int j = 0; j < 4; j++) w[j] = k[127-32*j -: 32] ^ fk[j];
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'((4*i + j) * 7);
            w[i+4] = w[i] ^ m_tkey(w[i+1] ^ w[i+2] ^ w[i+3] ^ ck);
            m_rk[i] = w[i+4];
        end
    endtask

    // ---------------- check / scoreboard ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int idx, input logic [31:0] val, input string req);
        exp_t it;
        it.idx = idx;
        it.val = val;
        it.req = req;
        sb_q.push_back(it);
        pushed++;
    endtask

    task automatic drain();
        wait (scored == pushed);
    endtask

    initial begin : monitor
        forever begin
            exp_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            @(negedge clk);
            rd_idx = 5'(it.idx);
            #1;
            chk(rd_key === it.val, it.req, rd_key, it.val);
            scored++;
        end
    end

    // ---------------- driver ----------------
    task automatic pulse_start(input logic [127:0] k);
        @(negedge clk);
        key   = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic timing_check();
        repeat (31) @(negedge clk);
        chk(done === 1'b0, "R4 early", 32'(done), 32'h0);
        @(negedge clk);
        chk(done === 1'b1, "R4 done at 32", 32'(done), 32'h1);
    endtask

    task automatic run_key(input logic [127:0] k, input string req);
        pulse_start(k);
        timing_check();
        m_expand(k);
        for (int i = 0; i < 32; i++) push(i, m_rk[i], req);
        drain();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    localparam logic [127:0] STD_KEY = 128'h0123456789abcdeffedcba9876543210;

    initial begin : main
        for (int c = 0; c < 256; c++) m_sbox[c] = m_aff(m_inv(m_aff(8'(c)) ^ 8'hD3)) ^ 8'hD3;
        // R8 model sanity anchor
        chk(m_sbox[0] == 8'hD6, "R8 model S(0)", 32'(m_sbox[0]), 32'hD6);

        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R1 in reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R1 after reset", 32'(done), 32'h0);

        // R2 R3 R8 R9: reference key with fixed anchors
        run_key(STD_KEY, "R3 std key");
        push(0,  32'hf12186f9, "R2 anchor rk0");
        push(31, 32'h9124a012, "R3 anchor rk31");
        drain();

        // R9 R8: zero key isolates constants and S-box
        run_key('0, "R9 zero key");
        run_key('1, "R8 ones key");

        // R6: restart mid-expansion
        pulse_start(128'h00112233445566778899aabbccddeeff);
        repeat (9) @(negedge clk);
        chk(done === 1'b0, "R6 mid run", 32'(done), 32'h0);
        run_key(128'h3c5a_96e1_0f1e_2d3c_4b5a_6978_8796_a5b4, "R6 restarted key");

        // R6: start after done drops done at once
        pulse_start(128'hdeadbeef_01234567_89abcdef_cafef00d);
        chk(done === 1'b0, "R6 start clears done", 32'(done), 32'h0);
        timing_check();
        m_expand(128'hdeadbeef_01234567_89abcdef_cafef00d);

        // R5: hold over idle cycles
        repeat (20) @(negedge clk);
        chk(done === 1'b1, "R5 done held", 32'(done), 32'h1);

        // R7 R5: descending read for decryption order
        for (int i = 31; i >= 0; i--) push(i, m_rk[i], "R7 reverse read");
        drain();
        chk(done === 1'b1, "R5 done after reads", 32'(done), 32'h1);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule